// File: doc/BRIEF.md
# SPI Peripheral Wake-Up Sequencer

This controller sits on the host side of a generic SPI link. After power-up it brings a peripheral out of reset and wakes it so that data transfer can begin. It issues single-word commands on a simple command port: a read or write flag, a function number, an address and a data word. An SPI master outside this block serializes those commands. The controller also watches the peripheral's interrupt line.

A `start_i` pulse runs the full power-up sequence. The sequence has five steps:
1. A fixed reset wait, sized from the clock frequency.
2. Repeated reads of the identification register, spaced by a programmable gap, until the expected word comes back.
3. A write that sets the wake bit in the control register.
4. A bounded wait for the peripheral's ready interrupt.
5. A read of the interrupt/status register to learn the cause.

A `resume_i` pulse brings the peripheral back from sleep. It runs only the last three steps. Success produces a one-cycle `ready_o` pulse. Either timeout leaves a latched error code and ends the sequence.

Top module: `spi_wake_seq`

## Requirements
- R1: After reset, `busy_o`, `ready_o` and `cmd_valid_o` are 0 and `err_o` is 0 (0 = no error, 1 = identification poll timeout, 2 = ready-interrupt timeout).
- R2: While `cmd_valid_o` is high and `cmd_ready_i` is low, the command stays valid with unchanged write flag, function, address and data. A write completes when it is accepted. A read completes when `rsp_valid_i` returns its word.
- R3: After `start_i`, the first command is presented no earlier than RESET_WAIT_US × CLK_KHZ / 1000 cycles later, and no more than 8 cycles beyond that count.
- R4: The identification poll is a read of function 0, address 0x14. After a response that does not match, the next poll read is presented no sooner than POLL_GAP + 3 cycles after the previous read was accepted. The wait counters never underflow.
- R5: When a poll read returns ID_WORD, the next command is a write to function 0, address 0x00, with data CFG_KEEP with bit 7 set.
- R6: If POLL_TRIES poll reads in a row all return a word other than ID_WORD, no further command is issued, `err_o` becomes 1 and `busy_o` falls.
- R7: After the wake write, an active level on `dev_irq_i` leads to a read of function 0 at address STAT_ADDR. The active level is high when `irq_pol_i` is 1 and low when it is 0.
- R8: The response to the status read is held on `status_o`. `ready_o` is high for exactly one cycle, the cycle after that response, and `busy_o` falls.
- R9: If no active interrupt arrives within IRQ_TMO cycles of the wake write, `err_o` becomes 2, `busy_o` falls and no status read is issued.
- R10: `resume_i` skips the reset wait and the polling, so the first command is the wake write.
- R11: `start_i` and `resume_i` are ignored while `busy_o` is high. An active interrupt while idle issues no command.
- R12: `err_o` keeps its value while idle and is cleared when the next `start_i` or `resume_i` is accepted. While `err_o` is nonzero, `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Run the full power-up wake sequence |
| resume_i | input | 1 | Run the wake-from-sleep sequence |
| irq_pol_i | input | 1 | Interrupt active level: 1 high, 0 low |
| dev_irq_i | input | 1 | Peripheral interrupt line (asynchronous) |
| cmd_valid_o | output | 1 | Command request to the SPI master |
| cmd_write_o | output | 1 | 1 write, 0 read |
| cmd_func_o | output | 2 | Function number (always 0 here) |
| cmd_addr_o | output | 15 | Register address |
| cmd_wdata_o | output | 32 | Write data |
| cmd_ready_i | input | 1 | SPI master accepts the command |
| rsp_valid_i | input | 1 | Read data returned |
| rsp_data_i | input | 32 | Read data word |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | One-cycle pulse: peripheral awake |
| err_o | output | 2 | Latched error code |
| status_o | output | 32 | Last interrupt/status word read |

## Verification
The assertions assume the SPI master behaves as a well-formed partner. It sends `rsp_valid_i` only for an accepted read, and only after that read is accepted. It never sends more than one response per read. The bench's responder follows exactly this model. It sends one response 1 to 3 cycles after each accepted read and never responds to writes. It drives `cmd_ready_i` randomly only while a command is pending. It raises the interrupt only after the wake write and holds it until the status read is accepted. The polarity is changed only while the block is idle, a few cycles before a sequence starts.

// File: rtl/spi_wake_pkg.sv
package spi_wake_pkg;
  localparam int ADDR_W = 15;
  localparam int DATA_W = 32;
  localparam int FUNC_W = 2;

  localparam logic [ADDR_W-1:0] ID_ADDR   = ADDR_W'(16'h0014);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(16'h0000);
  localparam int                WAKE_BIT  = 7;

  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_ID   = 2'd1;
  localparam logic [1:0] ERR_IRQ  = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_WAIT, S_POLL_REQ, S_POLL_RSP, S_POLL_GAP,
    S_WAKE_REQ, S_IRQ_WAIT, S_STAT_REQ, S_STAT_RSP
  } wake_state_e;

  // cycles to cover a wait given in microseconds at a clock given in kHz
  function automatic int reset_cycles(input longint khz, input longint us);
    return int'((khz * us) / 1000);
  endfunction

  function automatic logic [DATA_W-1:0] wake_word(input logic [DATA_W-1:0] keep);
    return keep | (DATA_W'(1) << WAKE_BIT);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int bits_for(input int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction
endpackage

// File: rtl/wake_down_cnt.sv
module wake_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R4: a wait counter is never decremented past zero
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i) |-> !zero_o);
endmodule

// File: rtl/wake_irq_sync.sv
module wake_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic pol_i,
  output logic act_o
);
  logic synced;

  generate
    if (STAGES < 2) begin : g_one
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= raw_i;
      end
      assign synced = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], raw_i};
      end
      assign synced = sh_q[STAGES-1];
    end
  endgenerate

  // R7: polarity select after the synchronizer
  assign act_o = pol_i ? synced : ~synced;
endmodule

// File: rtl/spi_wake_seq.sv
module spi_wake_seq import spi_wake_pkg::*; #(
  parameter int                CLK_KHZ       = 50000,
  parameter int                RESET_WAIT_US = 150000,
  parameter int                POLL_GAP      = 1000,
  parameter int                POLL_TRIES    = 64,
  parameter int                IRQ_TMO       = 500000,
  parameter int                SYNC_STAGES   = 2,
  parameter logic [DATA_W-1:0] ID_WORD       = 32'hFEED_BEAD,
  parameter logic [DATA_W-1:0] CFG_KEEP      = 32'h0000_0030,
  parameter logic [ADDR_W-1:0] STAT_ADDR     = 15'h0008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              resume_i,
  input  logic              irq_pol_i,
  input  logic              dev_irq_i,
  output logic              cmd_valid_o,
  output logic              cmd_write_o,
  output logic [FUNC_W-1:0] cmd_func_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_wdata_o,
  input  logic              cmd_ready_i,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [1:0]        err_o,
  output logic [DATA_W-1:0] status_o
);
  localparam int RESET_CYC = reset_cycles(CLK_KHZ, RESET_WAIT_US);
  localparam int TMR_W     = bits_for(max3(RESET_CYC, POLL_GAP, IRQ_TMO));
  localparam int TRY_W     = bits_for(POLL_TRIES);

  wake_state_e state_q, state_d;
  logic [1:0]        err_q;
  logic [DATA_W-1:0] status_q;
  logic              ready_q;

  // named internal events
  logic cmd_fire, id_hit, irq_act, tmr_zero, try_last;
  logic tmr_load, tmr_dec, try_load, try_dec;
  logic [TMR_W-1:0] tmr_val;
  logic err_set, err_clr, ready_d, stat_take;
  logic [1:0] err_code;

  wake_down_cnt #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val),
    .dec_i(tmr_dec), .zero_o(tmr_zero)
  );

  wake_down_cnt #(.W(TRY_W)) u_tries (
    .clk(clk), .rst_n(rst_n), .load_i(try_load),
    .val_i(TRY_W'(POLL_TRIES - 1)), .dec_i(try_dec), .zero_o(try_last)
  );

  wake_irq_sync #(.STAGES(SYNC_STAGES)) u_irq (
    .clk(clk), .rst_n(rst_n), .raw_i(dev_irq_i), .pol_i(irq_pol_i),
    .act_o(irq_act)
  );

  assign cmd_fire = cmd_valid_o && cmd_ready_i;
  assign id_hit   = (rsp_data_i == ID_WORD);

  always_comb begin
    state_d     = state_q;
    cmd_valid_o = 1'b0;
    cmd_write_o = 1'b0;
    cmd_func_o  = '0;
    cmd_addr_o  = '0;
    cmd_wdata_o = '0;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    tmr_dec     = 1'b0;
    try_load    = 1'b0;
    try_dec     = 1'b0;
    err_set     = 1'b0;
    err_clr     = 1'b0;
    err_code    = ERR_NONE;
    ready_d     = 1'b0;
    stat_take   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d  = S_RST_WAIT;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(RESET_CYC);
          err_clr  = 1'b1;
        end else if (resume_i) begin
          state_d = S_WAKE_REQ;
          err_clr = 1'b1;
        end
      end
      S_RST_WAIT: begin
        if (tmr_zero) begin
          state_d  = S_POLL_REQ;
          try_load = 1'b1;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      S_POLL_REQ: begin
        cmd_valid_o = 1'b1;
        cmd_addr_o  = ID_ADDR;
        if (cmd_fire) state_d = S_POLL_RSP;
      end
      S_POLL_RSP: begin
        if (rsp_valid_i) begin
          if (id_hit) begin
            state_d = S_WAKE_REQ;
          end else if (try_last) begin
            state_d  = S_IDLE;
            err_set  = 1'b1;
            err_code = ERR_ID;
          end else begin
            state_d  = S_POLL_GAP;
            try_dec  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(POLL_GAP);
          end
        end
      end
      S_POLL_GAP: begin
        if (tmr_zero) state_d = S_POLL_REQ;
        else          tmr_dec = 1'b1;
      end
      S_WAKE_REQ: begin
        cmd_valid_o = 1'b1;
        cmd_write_o = 1'b1;
        cmd_addr_o  = CTRL_ADDR;
        cmd_wdata_o = wake_word(CFG_KEEP);
        if (cmd_fire) begin
          state_d  = S_IRQ_WAIT;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(IRQ_TMO);
        end
      end
      S_IRQ_WAIT: begin
        if (irq_act) begin
          state_d = S_STAT_REQ;
        end else if (tmr_zero) begin
          state_d  = S_IDLE;
          err_set  = 1'b1;
          err_code = ERR_IRQ;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      S_STAT_REQ: begin
        cmd_valid_o = 1'b1;
        cmd_addr_o  = STAT_ADDR;
        if (cmd_fire) state_d = S_STAT_RSP;
      end
      S_STAT_RSP: begin
        if (rsp_valid_i) begin
          stat_take = 1'b1;
          ready_d   = 1'b1;
          state_d   = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      err_q    <= ERR_NONE;
      status_q <= '0;
      ready_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= ready_d;
      if (err_clr)      err_q <= ERR_NONE;
      else if (err_set) err_q <= err_code;
      if (stat_take)    status_q <= rsp_data_i;
    end
  end

  assign busy_o   = (state_q != S_IDLE);
  assign ready_o  = ready_q;
  assign err_o    = err_q;
  assign status_o = status_q;

  // R2: a pending command holds still until accepted
  a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o &&
      $stable({cmd_write_o, cmd_func_o, cmd_addr_o, cmd_wdata_o})));

  // R8: ready is a single-cycle pulse, directly after a response
  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);
  a_r8_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> ($past(rsp_valid_i) && !busy_o));

  // R12: an error code is only visible while idle
  a_r12_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o != ERR_NONE) |-> !busy_o);

  // R11: an accepted start while busy does not restart the reset wait
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> !(tmr_load && tmr_val == TMR_W'(RESET_CYC) && state_q != S_IDLE));
endmodule

// File: tb/spi_wake_seq_tb.sv
module spi_wake_seq_tb_top;
  localparam int  CLK_KHZ = 50000;
  localparam int  RWU     = 2;
  localparam int  RC      = CLK_KHZ * RWU / 1000;  // 100 cycles
  localparam int  GAP     = 8;
  localparam int  TRIES   = 5;
  localparam int  TMO     = 60;
  localparam logic [31:0] IDW  = 32'hA5C3_0F96;
  localparam logic [31:0] KEEP = 32'h0000_0030;
  localparam logic [14:0] STA  = 15'h0008;

  localparam int K_ID = 1, K_WAKE = 2, K_STAT = 3, K_OTHER = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, resume_i = 1'b0, irq_pol = 1'b1, dev_irq = 1'b0;
  logic cmd_valid, cmd_write, cmd_ready = 1'b0, rsp_valid = 1'b0;
  logic [1:0] cmd_func;
  logic [14:0] cmd_addr;
  logic [31:0] cmd_wdata, rsp_data = '0;
  logic busy, ready;
  logic [1:0] err;
  logic [31:0] status;

  always #10 clk = ~clk;  // 50 MHz

  spi_wake_seq #(
    .CLK_KHZ(CLK_KHZ), .RESET_WAIT_US(RWU), .POLL_GAP(GAP), .POLL_TRIES(TRIES),
    .IRQ_TMO(TMO), .ID_WORD(IDW), .CFG_KEEP(KEEP), .STAT_ADDR(STA)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .resume_i(resume_i),
    .irq_pol_i(irq_pol), .dev_irq_i(dev_irq), .cmd_valid_o(cmd_valid),
    .cmd_write_o(cmd_write), .cmd_func_o(cmd_func), .cmd_addr_o(cmd_addr),
    .cmd_wdata_o(cmd_wdata), .cmd_ready_i(cmd_ready), .rsp_valid_i(rsp_valid),
    .rsp_data_i(rsp_data), .busy_o(busy), .ready_o(ready), .err_o(err),
    .status_o(status)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // stimulus configuration (main process only)
  int          cfg_bad = 0, cfg_dly = 5;
  bit          cfg_irq_en = 1'b1, cfg_force = 1'b0;
  logic [31:0] cfg_status = '0;

  // responder state (responder process only)
  int log_cyc [0:255];
  int log_kind[0:255];
  int n_cmds = 0, n_ready = 0, n_ready_long = 0;
  logic [31:0] last_wake = '0;

  function automatic logic [31:0] exp_wake(input logic [31:0] keep);
    logic [31:0] w;
    w = keep;
    w[7] = 1'b1;
    return w;
  endfunction

  function automatic int exp_err(input bit resume, input int bad, input bit irq_en);
    if (!resume && bad >= TRIES) return 1;
    return irq_en ? 0 : 2;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // peripheral stand-in, acting at falling edges
  initial begin : responder
    int rsp_cnt, irq_cnt, id_run, kind;
    bit irq_on, prev_ready;
    logic [31:0] pend;
    rsp_cnt = 0; irq_cnt = 0; id_run = 0; irq_on = 0; prev_ready = 0; pend = '0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin rsp_valid = 1'b1; rsp_data = pend; end
      end
      if (irq_cnt > 0) begin
        irq_cnt--;
        if (irq_cnt == 0) irq_on = 1'b1;
      end
      if (!busy) begin id_run = 0; irq_on = 1'b0; irq_cnt = 0; end
      dev_irq = (irq_on || cfg_force) ? irq_pol : ~irq_pol;
      if (ready) begin
        n_ready++;
        if (prev_ready) n_ready_long++;
      end
      prev_ready = ready;
      cmd_ready = 1'b0;
      if (cmd_valid && rsp_cnt == 0 && ($urandom % 4) != 0) begin
        cmd_ready = 1'b1;
        kind = K_OTHER;
        if (cmd_func == 2'd0 && !cmd_write && cmd_addr == 15'h0014) begin
          kind = K_ID;
          pend = (id_run < cfg_bad) ? (IDW ^ (32'd1 << ($urandom % 32))) : IDW;
          id_run++;
          rsp_cnt = 1 + ($urandom % 3);
        end else if (cmd_func == 2'd0 && cmd_write && cmd_addr == 15'h0000) begin
          kind = K_WAKE;
          last_wake = cmd_wdata;
          if (cfg_irq_en) irq_cnt = cfg_dly;
        end else if (cmd_func == 2'd0 && !cmd_write && cmd_addr == STA) begin
          kind = K_STAT;
          pend = cfg_status;
          irq_on = 1'b0;
          rsp_cnt = 1 + ($urandom % 3);
        end
        log_cyc[n_cmds % 256]  = cyc;
        log_kind[n_cmds % 256] = kind;
        n_cmds++;
      end
    end
  end

  task automatic run_seq(input bit resume, input int bad, input bit irq_en,
                         input bit pol, input int dly, input logic [31:0] stat,
                         input bit poke);
    int n0, r0, t0, e_id, e_wake, e_stat, idx;
    bit ok;
    @(negedge clk);
    cfg_bad = bad; cfg_irq_en = irq_en; cfg_dly = dly; cfg_status = stat;
    irq_pol = pol;
    repeat (5) @(negedge clk);
    n0 = n_cmds; r0 = n_ready;
    if (resume) resume_i = 1'b1; else start_i = 1'b1;
    t0 = cyc;
    @(negedge clk);
    resume_i = 1'b0; start_i = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      start_i = 1'b1;  // R11: must be ignored mid-sequence
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int i = 0; i < 4000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    e_id   = resume ? 0 : ((bad + 1 < TRIES) ? bad + 1 : TRIES);
    e_wake = (resume || bad < TRIES) ? 1 : 0;
    e_stat = (e_wake == 1 && irq_en) ? 1 : 0;
    chk(!busy, "R8", "busy after sequence", busy, 0);
    chk((n_cmds - n0) == e_id + e_wake + e_stat, "R6", "command count",
        n_cmds - n0, e_id + e_wake + e_stat);
    if (!resume) begin
      chk(log_cyc[n0 % 256] - t0 >= RC && log_cyc[n0 % 256] - t0 <= RC + 8,
          "R3", "first command delay", log_cyc[n0 % 256] - t0, RC + 2);
    end else begin
      chk(log_kind[n0 % 256] == K_WAKE, "R10", "first command kind",
          log_kind[n0 % 256], K_WAKE);
    end
    for (int j = 0; j < e_id; j++) begin
      idx = (n0 + j) % 256;
      chk(log_kind[idx] == K_ID, "R4", "poll read kind", log_kind[idx], K_ID);
      if (j > 0)
        chk(log_cyc[idx] - log_cyc[(n0 + j - 1) % 256] >= GAP + 3, "R4", "poll spacing",
            log_cyc[idx] - log_cyc[(n0 + j - 1) % 256], GAP + 3);
    end
    if (e_wake == 1) begin
      idx = (n0 + e_id) % 256;
      chk(log_kind[idx] == K_WAKE, "R5", "wake write follows match", log_kind[idx], K_WAKE);
      chk(last_wake == exp_wake(KEEP), "R5", "wake data", last_wake, exp_wake(KEEP));
    end
    if (e_stat == 1) begin
      idx = (n0 + e_id + 1) % 256;
      chk(log_kind[idx] == K_STAT, "R7", "status read after irq", log_kind[idx], K_STAT);
      chk(status == stat, "R8", "status word", status, stat);
    end
    ok = (n_ready - r0) == e_stat;
    chk(ok, "R8", "ready pulses", n_ready - r0, e_stat);
    chk(n_ready_long == 0, "R8", "ready wider than one cycle", n_ready_long, 0);
    chk(err == exp_err(resume, bad, irq_en), (bad >= TRIES && !resume) ? "R6" : "R9",
        "error code", err, exp_err(resume, bad, irq_en));
  endtask

  initial begin : main
    int n0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !ready && !cmd_valid && err == 2'd0, "R1", "reset outputs",
        {busy, ready, cmd_valid, err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !cmd_valid, "R1", "idle after reset", {busy, cmd_valid}, 0);

    // R11: interrupt while idle is ignored
    n0 = n_cmds;
    cfg_force = 1'b1;
    repeat (20) @(negedge clk);
    chk(n_cmds == n0 && !busy, "R11", "idle irq issued command", n_cmds - n0, 0);
    cfg_force = 1'b0;
    repeat (4) @(negedge clk);

    // directed cases
    run_seq(1'b0, 2, 1'b1, 1'b1, 5, 32'h1234_5678, 1'b1);      // R3 R4 R5 R7 R8 R11
    run_seq(1'b0, 0, 1'b1, 1'b0, 9, 32'h0BAD_CAFE, 1'b0);      // R7 low-active
    run_seq(1'b0, TRIES, 1'b1, 1'b1, 5, 32'h0, 1'b0);          // R6 poll timeout
    repeat (12) @(negedge clk);
    chk(err == 2'd1, "R12", "error held while idle", err, 1);
    run_seq(1'b1, 0, 1'b0, 1'b1, 5, 32'h0, 1'b0);              // R9 R10 irq timeout
    run_seq(1'b1, 0, 1'b1, 1'b0, 3, 32'hC0DE_0001, 1'b0);      // R10 R12 cleared
    chk(err == 2'd0, "R12", "error cleared by resume", err, 0);
    run_seq(1'b0, TRIES - 1, 1'b1, 1'b1, TMO - 10, 32'h55AA_55AA, 1'b0); // last try

    // random mix
    for (int k = 0; k < 8; k++) begin
      run_seq(1'($urandom % 3 == 0), int'($urandom % (TRIES + 1)),
              1'($urandom % 4 != 0), 1'($urandom % 2), 1 + int'($urandom % 40),
              $urandom, 1'($urandom % 2));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule